// File: doc/BRIEF.md
# Two-Channel Pointer-Addressed Register Front End

This block is the host-facing register file of a two-channel serial controller. The host sees each channel as a pair of byte ports, a control port and a data port. Behind each control port sit sixteen write registers and sixteen read registers. They are reached through a per-channel register pointer. A control write while the pointer is zero selects the next register. The following control access then reaches that register, and the pointer drops back to zero afterwards. A strap input decides which of two adjacent address bits picks the channel and which picks the port.

The block keeps the write registers and drives them out on a flat configuration bus for the neighbouring blocks. It serves the status and baud-divisor read registers and carries out the channel reset commands. It also keeps the receive-available and transmit-empty flags, latches received bytes, and pulses strobes when the host touches a data port. All host accesses are single-cycle strobes. Read data is registered.

Top module: `dual_chan_regport`

## Requirements
- R1: The pair of address bits at `ADDR_LSB` decodes the access. With `addr_swap`=0, the lower bit is the port (0 control, 1 data) and the upper bit is the channel. With `addr_swap`=1 the two roles are exchanged. Channel value 0 is channel B (bus index 0) and value 1 is channel A (bus index 1).
- R2: A control write while the pointer is 0 loads the pointer with write-data bits 2:0. When bits 5:3 equal 3'b001, it also adds 8 to the pointer. Any other value in bits 5:3 adds nothing.
- R3: A control write while the pointer is nonzero stores the byte into the write register at the pointer and returns the pointer to 0. Write register n of channel c appears on `cfg_wregs[(c*16+n)*8 +: 8]`.
- R4: A control read places the read register at the pointer on `host_rdata` one cycle later and returns the pointer to 0. Read registers other than 0, 1, 12 and 13 read as 0x00.
- R5: Read registers 12 and 13 return the last value written to write registers 12 and 13 of the same channel.
- R6: A write to register 9 is a reset command and is never stored. Bits 7:6 = 01 reset channel B, 10 reset channel A, and 11 reset both, whichever channel's port carries the write. A reset channel returns to its reset state, including the pointer and the receive latch.
- R7: After reset, write registers 4, 9, 11, 14 and 15 hold 0x04, 0xC0, 0x08, 0x30 and 0xF8, and all others hold 0. Read register 0 is 0x44 and read register 1 is 0x07.
- R8: A data write pulses `tx_pulse` for that channel and puts the byte on `tx_byte` one cycle later. It also sets read-register-0 bit 2 (transmit empty) and read-register-1 bit 0 (all sent).
- R9: A byte on `rx_valid` is taken only when write-register-3 bit 0 is 1 and read-register-0 bit 0 is 0. Taking it latches the byte, sets read-register-0 bit 0 and pulses `rx_take` one cycle later.
- R10: A data read returns the latched receive byte, clears read-register-0 bit 0 and pulses `rd_pulse` for that channel one cycle later.
- R11: Accesses on consecutive cycles each see the pointer left by the access before.
- R12: When `host_wr` and `host_rd` are both high, only the write takes effect and `host_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_swap | input | 1 | Strap exchanging the channel and port address bits |
| host_addr | input | ADDR_W | Host byte address |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Single-cycle read strobe |
| host_wdata | input | DATA_W | Write byte |
| host_rdata | output | DATA_W | Registered read byte |
| rx_valid | input | 2 | Per-channel received-byte offer |
| rx_byte | input | 2*DATA_W | Offered bytes, channel c at bits c*8 |
| rx_take | output | 2 | Offered byte was accepted |
| tx_pulse | output | 2 | Data-port write happened |
| tx_byte | output | DATA_W | Byte of the last data-port write |
| rd_pulse | output | 2 | Data-port read happened |
| cfg_wregs | output | 2*16*DATA_W | All write registers of both channels |

## Verification
The assertions watch the pointer on every cycle. They check that a pointer load follows the bits 2:0 and command-field rule, and that every control read leaves the pointer at zero. They also check that each data write yields exactly one transmit pulse carrying the written byte, that a receive acceptance always follows an offer, and that a both-channel reset leaves both pointers and both mode registers at their reset values. The bench scenarios cover what only sequences can show. These are the read values after pointer chains under both strap settings and the mirroring of the divisor bytes. They also include the refusal of a second byte until the data read, single-channel resets that leave the other channel intact, the write-register-9 byte never being stored, and the write-wins rule for a collision.

// File: rtl/drp_pkg.sv
package drp_pkg;
   localparam int NUM_CH      = 2;
   localparam int CH_B        = 0;
   localparam int CH_A        = 1;
   localparam int WR_PTR_REG  = 0;
   localparam int WR_RXMODE   = 3;
   localparam int WR_RSTCMD   = 9;
   localparam int WR_DIV_LO   = 12;
   localparam int WR_DIV_HI   = 13;
   localparam int RR_STAT     = 0;
   localparam int RR_SPEC     = 1;
   localparam int CMD_LSB     = 3;
   localparam logic [2:0] CMD_UPPER_BANK = 3'b001;
   localparam int RST_CMD_LSB = 6;
   localparam int STAT_RXAV   = 0;
   localparam int STAT_TXMT   = 2;
   localparam int SPEC_SENT   = 0;
   localparam logic [7:0] RR0_INIT = 8'h44;
   localparam logic [7:0] RR1_INIT = 8'h07;

   function automatic logic [7:0] wr_reset_val(input int idx);
      case (idx)
         4:       return 8'h04;
         9:       return 8'hC0;
         11:      return 8'h08;
         14:      return 8'h30;
         15:      return 8'hF8;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/drp_addr_decode.sv
module drp_addr_decode #(
   parameter int ADDR_W   = 2,
   parameter int ADDR_LSB = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              swap,
   output logic              ch_sel,
   output logic              is_data
);
   localparam int LO = ADDR_LSB;
   localparam int HI = ADDR_LSB + 1;

   generate
      if (HI >= ADDR_W) begin : g_bad_addr
         $error("address pair does not fit in ADDR_W");
      end
   endgenerate

   always_comb begin
      if (swap) begin
         ch_sel  = addr[LO];
         is_data = addr[HI];
      end else begin
         ch_sel  = addr[HI];
         is_data = addr[LO];
      end
   end
endmodule

// File: rtl/drp_chan_regs.sv
module drp_chan_regs
   import drp_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 16,
   parameter int PTR_W    = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ctl_wr,
   input  logic                       ctl_rd,
   input  logic                       dat_wr,
   input  logic                       dat_rd,
   input  logic                       chan_rst,
   input  logic [DATA_W-1:0]          wdata,
   input  logic                       rx_valid,
   input  logic [DATA_W-1:0]          rx_byte,
   output logic [PTR_W-1:0]           ptr,
   output logic [DATA_W-1:0]          ctl_rdata,
   output logic [DATA_W-1:0]          rx_hold,
   output logic [NUM_REGS*DATA_W-1:0] wregs,
   output logic [1:0]                 rst_cmd,
   output logic                       rx_take
);
   localparam int LOW_PTR_W = PTR_W - 1;

   logic [PTR_W-1:0]  ptr_q;
   logic [DATA_W-1:0] rr0_q;
   logic [DATA_W-1:0] rr1_q;
   logic [DATA_W-1:0] rx_q;
   logic              take_q;
   logic              take_now;
   logic              rx_en;
   logic [PTR_W-1:0]  ptr_load;

   assign ptr_load = {(wdata[CMD_LSB +: 3] == CMD_UPPER_BANK), wdata[LOW_PTR_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (chan_rst) begin
         ptr_q <= '0;
      end else if (ctl_wr) begin
         if (ptr_q == PTR_W'(WR_PTR_REG)) ptr_q <= ptr_load;
         else                             ptr_q <= '0;
      end else if (ctl_rd) begin
         ptr_q <= '0;
      end
   end

   generate
      for (genvar n = 0; n < NUM_REGS; n++) begin : g_wr
         logic [DATA_W-1:0] q;
         if (n == WR_PTR_REG || n == WR_RSTCMD) begin : g_fixed
            assign q = DATA_W'(wr_reset_val(n));
         end else begin : g_store
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= DATA_W'(wr_reset_val(n));
               else if (chan_rst)
                  q <= DATA_W'(wr_reset_val(n));
               else if (ctl_wr && ptr_q == PTR_W'(n))
                  q <= wdata;
            end
         end
         assign wregs[n*DATA_W +: DATA_W] = q;
      end
   endgenerate

   assign rst_cmd = (ctl_wr && ptr_q == PTR_W'(WR_RSTCMD)) ?
                    wdata[RST_CMD_LSB +: 2] : 2'b00;

   assign rx_en    = wregs[WR_RXMODE*DATA_W];
   assign take_now = rx_valid && rx_en && !rr0_q[STAT_RXAV] && !chan_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr0_q  <= DATA_W'(RR0_INIT);
         rr1_q  <= DATA_W'(RR1_INIT);
         rx_q   <= '0;
         take_q <= 1'b0;
      end else if (chan_rst) begin
         rr0_q  <= DATA_W'(RR0_INIT);
         rr1_q  <= DATA_W'(RR1_INIT);
         rx_q   <= '0;
         take_q <= 1'b0;
      end else begin
         take_q <= take_now;
         if (dat_wr) begin
            rr0_q[STAT_TXMT] <= 1'b1;
            rr1_q[SPEC_SENT] <= 1'b1;
         end
         if (take_now) begin
            rr0_q[STAT_RXAV] <= 1'b1;
            rx_q             <= rx_byte;
         end else if (dat_rd) begin
            rr0_q[STAT_RXAV] <= 1'b0;
         end
      end
   end

   always_comb begin
      case (ptr_q)
         PTR_W'(RR_STAT):   ctl_rdata = rr0_q;
         PTR_W'(RR_SPEC):   ctl_rdata = rr1_q;
         PTR_W'(WR_DIV_LO): ctl_rdata = wregs[WR_DIV_LO*DATA_W +: DATA_W];
         PTR_W'(WR_DIV_HI): ctl_rdata = wregs[WR_DIV_HI*DATA_W +: DATA_W];
         default:           ctl_rdata = '0;
      endcase
   end

   assign ptr     = ptr_q;
   assign rx_hold = rx_q;
   assign rx_take = take_q;
endmodule

// File: rtl/dual_chan_regport.sv
module dual_chan_regport
   import drp_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 16,
   parameter int ADDR_W   = 2,
   parameter int ADDR_LSB = 0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              addr_swap,
   input  logic [ADDR_W-1:0]                 host_addr,
   input  logic                              host_wr,
   input  logic                              host_rd,
   input  logic [DATA_W-1:0]                 host_wdata,
   output logic [DATA_W-1:0]                 host_rdata,
   input  logic [NUM_CH-1:0]                 rx_valid,
   input  logic [NUM_CH*DATA_W-1:0]          rx_byte,
   output logic [NUM_CH-1:0]                 rx_take,
   output logic [NUM_CH-1:0]                 tx_pulse,
   output logic [DATA_W-1:0]                 tx_byte,
   output logic [NUM_CH-1:0]                 rd_pulse,
   output logic [NUM_CH*NUM_REGS*DATA_W-1:0] cfg_wregs
);
   localparam int PTR_W  = $clog2(NUM_REGS);
   localparam int BANK_W = NUM_REGS * DATA_W;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("DATA_W must be 8: command fields sit at fixed bit positions");
      end
      if (NUM_REGS != 16) begin : g_bad_depth
         $error("NUM_REGS must be 16: the pointer bank bit adds 8");
      end
   endgenerate

   logic                            acc_ch;
   logic                            acc_data;
   logic [NUM_CH-1:0]               ctl_wr;
   logic [NUM_CH-1:0]               ctl_rd;
   logic [NUM_CH-1:0]               dat_wr;
   logic [NUM_CH-1:0]               dat_rd;
   logic [NUM_CH-1:0]               chan_rst;
   logic [NUM_CH-1:0][PTR_W-1:0]    chan_ptr;
   logic [NUM_CH-1:0][DATA_W-1:0]   chan_ctl_rd;
   logic [NUM_CH-1:0][DATA_W-1:0]   chan_rx;
   logic [NUM_CH-1:0][1:0]          chan_cmd;
   logic [1:0]                      any_cmd;
   logic                            rd_only;

   drp_addr_decode #(
      .ADDR_W   (ADDR_W),
      .ADDR_LSB (ADDR_LSB)
   ) u_dec (
      .addr    (host_addr),
      .swap    (addr_swap),
      .ch_sel  (acc_ch),
      .is_data (acc_data)
   );

   assign rd_only = host_rd && !host_wr;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic hit;
         assign hit       = (acc_ch == 1'(c));
         assign ctl_wr[c] = host_wr && !acc_data && hit;
         assign dat_wr[c] = host_wr &&  acc_data && hit;
         assign ctl_rd[c] = rd_only && !acc_data && hit;
         assign dat_rd[c] = rd_only &&  acc_data && hit;

         drp_chan_regs #(
            .DATA_W   (DATA_W),
            .NUM_REGS (NUM_REGS),
            .PTR_W    (PTR_W)
         ) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_wr    (ctl_wr[c]),
            .ctl_rd    (ctl_rd[c]),
            .dat_wr    (dat_wr[c]),
            .dat_rd    (dat_rd[c]),
            .chan_rst  (chan_rst[c]),
            .wdata     (host_wdata),
            .rx_valid  (rx_valid[c]),
            .rx_byte   (rx_byte[c*DATA_W +: DATA_W]),
            .ptr       (chan_ptr[c]),
            .ctl_rdata (chan_ctl_rd[c]),
            .rx_hold   (chan_rx[c]),
            .wregs     (cfg_wregs[c*BANK_W +: BANK_W]),
            .rst_cmd   (chan_cmd[c]),
            .rx_take   (rx_take[c])
         );
      end
   endgenerate

   // a reset command from either channel's port may hit either channel
   always_comb begin
      any_cmd = '0;
      for (int c = 0; c < NUM_CH; c++) any_cmd |= chan_cmd[c];
   end
   assign chan_rst[CH_B] = any_cmd[0];
   assign chan_rst[CH_A] = any_cmd[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata <= '0;
         tx_pulse   <= '0;
         tx_byte    <= '0;
         rd_pulse   <= '0;
      end else begin
         tx_pulse <= dat_wr;
         rd_pulse <= dat_rd;
         if (|dat_wr) tx_byte <= host_wdata;
         if (rd_only) host_rdata <= acc_data ? chan_rx[acc_ch] : chan_ctl_rd[acc_ch];
      end
   end
endmodule

// File: rtl/drp_checker.sv
module drp_checker #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 2,
   parameter int ADDR_LSB = 0,
   parameter int PTR_W    = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   addr_swap,
   input logic [ADDR_W-1:0]      host_addr,
   input logic                   host_wr,
   input logic                   host_rd,
   input logic [DATA_W-1:0]      host_wdata,
   input logic [1:0]             rx_valid,
   input logic [1:0]             rx_take,
   input logic [1:0]             tx_pulse,
   input logic [DATA_W-1:0]      tx_byte,
   input logic [1:0][PTR_W-1:0]  chan_ptr,
   input logic [DATA_W-1:0]      mode_b,
   input logic [DATA_W-1:0]      mode_a
);
   logic c_ch;
   logic c_data;

   always_comb begin
      c_ch   = addr_swap ? host_addr[ADDR_LSB]   : host_addr[ADDR_LSB+1];
      c_data = addr_swap ? host_addr[ADDR_LSB+1] : host_addr[ADDR_LSB];
   end

   assert_tx_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_pulse));

   assert_tx_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && c_data) |=>
         (tx_pulse == (2'b01 << $past(c_ch))) && (tx_byte == $past(host_wdata)));

   assert_reset_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !c_data && chan_ptr[c_ch] == PTR_W'(9) && host_wdata[7:6] == 2'b11) |=>
         (chan_ptr[0] == '0) && (chan_ptr[1] == '0) &&
         (mode_b == 8'h04) && (mode_a == 8'h04));

   generate
      for (genvar c = 0; c < 2; c++) begin : g_chk
         assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr && !c_data && c_ch == 1'(c) && chan_ptr[c] == '0) |=>
               chan_ptr[c] == {($past(host_wdata[5:3]) == 3'b001), $past(host_wdata[2:0])});

         assert_ptr_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (host_rd && !host_wr && !c_data && c_ch == 1'(c)) |=> chan_ptr[c] == '0);

         assert_take_needs_offer_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rx_take[c] |-> $past(rx_valid[c]));
      end
   endgenerate
endmodule

bind dual_chan_regport drp_checker #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .ADDR_LSB (ADDR_LSB),
   .PTR_W    (PTR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr_swap  (addr_swap),
   .host_addr  (host_addr),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .host_wdata (host_wdata),
   .rx_valid   (rx_valid),
   .rx_take    (rx_take),
   .tx_pulse   (tx_pulse),
   .tx_byte    (tx_byte),
   .chan_ptr   (chan_ptr),
   .mode_b     (cfg_wregs[4*DATA_W +: DATA_W]),
   .mode_a     (cfg_wregs[(NUM_REGS+4)*DATA_W +: DATA_W])
);

// File: tb/tb_dual_chan_regport.sv
module tb_dual_chan_regport;
   localparam int OP_CW = 0;
   localparam int OP_CR = 1;
   localparam int OP_DW = 2;
   localparam int OP_DR = 3;
   localparam int NV    = 32;

   // fields: req[25:22] op[21:20] strap[19] addr[18:17] chk[16] wdata[15:8] exp[7:0]
   // strap 0: B ctl 00, B data 01, A ctl 10, A data 11; strap 1: B ctl 00, A ctl 01, B data 10, A data 11
   localparam logic [25:0] VEC [NV] = '{
      {4'd7,  2'd1, 1'b0, 2'b00, 1'b1, 8'h00, 8'h44},  // R7 RR0 of B
      {4'd7,  2'd1, 1'b0, 2'b10, 1'b1, 8'h00, 8'h44},  // R7 RR0 of A
      {4'd2,  2'd0, 1'b0, 2'b00, 1'b0, 8'h01, 8'h00},
      {4'd7,  2'd1, 1'b0, 2'b00, 1'b1, 8'h00, 8'h07},  // R7 RR1
      {4'd2,  2'd0, 1'b0, 2'b10, 1'b0, 8'h0C, 8'h00},  // R2 bank bit
      {4'd5,  2'd0, 1'b0, 2'b10, 1'b0, 8'h25, 8'h00},
      {4'd2,  2'd0, 1'b0, 2'b10, 1'b0, 8'h0C, 8'h00},
      {4'd5,  2'd1, 1'b0, 2'b10, 1'b1, 8'h00, 8'h25},  // R5 low divisor
      {4'd2,  2'd0, 1'b0, 2'b10, 1'b0, 8'h0D, 8'h00},
      {4'd5,  2'd0, 1'b0, 2'b10, 1'b0, 8'h9A, 8'h00},
      {4'd2,  2'd0, 1'b0, 2'b10, 1'b0, 8'h0D, 8'h00},
      {4'd5,  2'd1, 1'b0, 2'b10, 1'b1, 8'h00, 8'h9A},  // R5 high divisor
      {4'd3,  2'd0, 1'b0, 2'b00, 1'b0, 8'h05, 8'h00},
      {4'd3,  2'd0, 1'b0, 2'b00, 1'b0, 8'h60, 8'h00},
      {4'd3,  2'd1, 1'b0, 2'b00, 1'b1, 8'h00, 8'h44},  // R3 pointer back at 0
      {4'd4,  2'd0, 1'b0, 2'b00, 1'b0, 8'h03, 8'h00},
      {4'd4,  2'd1, 1'b0, 2'b00, 1'b1, 8'h00, 8'h00},  // R4 unpopulated reads 0
      {4'd2,  2'd0, 1'b0, 2'b00, 1'b0, 8'h0C, 8'h00},
      {4'd2,  2'd0, 1'b0, 2'b00, 1'b0, 8'h3C, 8'h00},
      {4'd2,  2'd0, 1'b0, 2'b00, 1'b0, 8'h2C, 8'h00},  // field 101: no bank bit
      {4'd2,  2'd1, 1'b0, 2'b00, 1'b1, 8'h00, 8'h00},  // R2 went to 4, not 12
      {4'd2,  2'd0, 1'b0, 2'b00, 1'b0, 8'h0C, 8'h00},
      {4'd2,  2'd1, 1'b0, 2'b00, 1'b1, 8'h00, 8'h3C},
      {4'd1,  2'd0, 1'b1, 2'b01, 1'b0, 8'h0C, 8'h00},  // R1 strap: A control
      {4'd1,  2'd1, 1'b1, 2'b01, 1'b1, 8'h00, 8'h25},
      {4'd1,  2'd0, 1'b1, 2'b00, 1'b0, 8'h0C, 8'h00},
      {4'd1,  2'd1, 1'b1, 2'b00, 1'b1, 8'h00, 8'h3C},
      {4'd8,  2'd2, 1'b1, 2'b11, 1'b0, 8'hA7, 8'h00},
      {4'd8,  2'd0, 1'b1, 2'b01, 1'b0, 8'h01, 8'h00},
      {4'd8,  2'd1, 1'b1, 2'b01, 1'b1, 8'h00, 8'h07},  // R8 all sent kept
      {4'd8,  2'd2, 1'b0, 2'b01, 1'b0, 8'h33, 8'h00},
      {4'd8,  2'd1, 1'b0, 2'b00, 1'b1, 8'h00, 8'h44}   // R8 transmit empty kept
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         addr_swap = 1'b0;
   logic [1:0]   host_addr = '0;
   logic         host_wr = 1'b0;
   logic         host_rd = 1'b0;
   logic [7:0]   host_wdata = '0;
   logic [7:0]   host_rdata;
   logic [1:0]   rx_valid = '0;
   logic [15:0]  rx_byte = '0;
   logic [1:0]   rx_take;
   logic [1:0]   tx_pulse;
   logic [7:0]   tx_byte;
   logic [1:0]   rd_pulse;
   logic [255:0] cfg_wregs;

   int unsigned n_tests = 0;
   int unsigned n_fail  = 0;
   bit          done    = 1'b0;

   always #4 clk = ~clk;

   dual_chan_regport dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_swap  (addr_swap),
      .host_addr  (host_addr),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .rx_valid   (rx_valid),
      .rx_byte    (rx_byte),
      .rx_take    (rx_take),
      .tx_pulse   (tx_pulse),
      .tx_byte    (tx_byte),
      .rd_pulse   (rd_pulse),
      .cfg_wregs  (cfg_wregs)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] wr_init(input int n);
      case (n)
         4: return 8'h04;  9: return 8'hC0;  11: return 8'h08;
         14: return 8'h30; 15: return 8'hF8; default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] wreg(input int ch, input int n);
      return cfg_wregs[(ch*16+n)*8 +: 8];
   endfunction

   task automatic acc(input int op, input logic s, input logic [1:0] a, input logic [7:0] d);
      addr_swap  = s;
      host_addr  = a;
      host_wdata = d;
      host_wr    = (op == OP_CW || op == OP_DW);
      host_rd    = (op == OP_CR || op == OP_DR);
      @(negedge clk);
      host_wr = 1'b0;
      host_rd = 1'b0;
   endtask

   task automatic offer(input int ch, input logic [7:0] d);
      rx_valid[ch]        = 1'b1;
      rx_byte[ch*8 +: 8]  = d;
      @(negedge clk);
      rx_valid = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 reset state
      check("R7 rdata", host_rdata, 8'h00);
      check("R7 tx_pulse", tx_pulse, 2'b00);
      check("R7 rx_take", rx_take, 2'b00);
      for (int ch = 0; ch < 2; ch++)
         for (int n = 0; n < 16; n++)
            check($sformatf("R7 wreg ch%0d n%0d", ch, n), wreg(ch, n), wr_init(n));

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [25:0] e;
         e = VEC[i];
         acc(int'(e[21:20]), e[19], e[18:17], e[15:8]);
         if (e[16]) check($sformatf("R%0d vector %0d", e[25:22], i), host_rdata, e[7:0]);
      end
      check("R3 WR5 of B stored", wreg(0, 5), 8'h60);
      check("R3 WR12 of A stored", wreg(1, 12), 8'h25);

      // R8 transmit strobes
      acc(OP_DW, 1'b0, 2'b11, 8'h5A);
      check("R8 tx_pulse A", tx_pulse, 2'b10);
      check("R8 tx_byte A", tx_byte, 8'h5A);
      @(negedge clk);
      check("R8 pulse single cycle", tx_pulse, 2'b00);
      acc(OP_DW, 1'b0, 2'b01, 8'hC3);
      check("R8 tx_pulse B", tx_pulse, 2'b01);
      check("R8 tx_byte B", tx_byte, 8'hC3);

      // R9 / R10 receive path
      offer(0, 8'h77);
      check("R9 refused while disabled", rx_take, 2'b00);
      acc(OP_CR, 1'b0, 2'b00, 8'h00);
      check("R9 flag clear while disabled", host_rdata, 8'h44);
      acc(OP_CW, 1'b0, 2'b00, 8'h03);
      acc(OP_CW, 1'b0, 2'b00, 8'h01);
      offer(0, 8'h77);
      check("R9 accepted", rx_take, 2'b01);
      acc(OP_CR, 1'b0, 2'b00, 8'h00);
      check("R9 available flag", host_rdata, 8'h45);
      offer(0, 8'h88);
      check("R9 second byte refused", rx_take, 2'b00);
      acc(OP_DR, 1'b0, 2'b01, 8'h00);
      check("R10 data read byte", host_rdata, 8'h77);
      check("R10 rd_pulse", rd_pulse, 2'b01);
      acc(OP_CR, 1'b0, 2'b00, 8'h00);
      check("R10 flag cleared", host_rdata, 8'h44);

      // R6 reset commands
      acc(OP_CW, 1'b0, 2'b10, 8'h04); acc(OP_CW, 1'b0, 2'b10, 8'h55);
      acc(OP_CW, 1'b0, 2'b00, 8'h04); acc(OP_CW, 1'b0, 2'b00, 8'h66);
      acc(OP_CW, 1'b0, 2'b10, 8'h03); acc(OP_CW, 1'b0, 2'b10, 8'h01);
      offer(1, 8'h11);
      check("R9 accepted on A", rx_take, 2'b10);
      acc(OP_CW, 1'b0, 2'b00, 8'h09); acc(OP_CW, 1'b0, 2'b00, 8'h40);
      check("R6 B reset WR4", wreg(0, 4), 8'h04);
      check("R6 B reset WR3", wreg(0, 3), 8'h00);
      check("R6 A untouched WR4", wreg(1, 4), 8'h55);
      check("R6 A untouched WR3", wreg(1, 3), 8'h01);
      check("R6 WR9 not stored", wreg(0, 9), 8'hC0);
      acc(OP_CR, 1'b0, 2'b10, 8'h00);
      check("R6 A flag kept", host_rdata, 8'h45);
      acc(OP_CW, 1'b0, 2'b00, 8'h09); acc(OP_CW, 1'b0, 2'b00, 8'h80);
      check("R6 A reset from B port WR4", wreg(1, 4), 8'h04);
      check("R6 A reset WR3", wreg(1, 3), 8'h00);
      acc(OP_CR, 1'b0, 2'b10, 8'h00);
      check("R6 A flag reset", host_rdata, 8'h44);
      acc(OP_DR, 1'b0, 2'b11, 8'h00);
      check("R6 A latch reset", host_rdata, 8'h00);
      acc(OP_CW, 1'b0, 2'b00, 8'h04); acc(OP_CW, 1'b0, 2'b00, 8'h66);
      acc(OP_CW, 1'b0, 2'b10, 8'h04); acc(OP_CW, 1'b0, 2'b10, 8'h55);
      acc(OP_CW, 1'b0, 2'b10, 8'h09); acc(OP_CW, 1'b0, 2'b10, 8'hC0);
      check("R6 both reset B", wreg(0, 4), 8'h04);
      check("R6 both reset A", wreg(1, 4), 8'h04);
      acc(OP_CW, 1'b0, 2'b00, 8'h09); acc(OP_CW, 1'b0, 2'b00, 8'h17);
      check("R6 no-command byte not stored", wreg(0, 9), 8'hC0);

      // R12 write wins over read
      acc(OP_CR, 1'b0, 2'b00, 8'h00);
      check("R12 prior read", host_rdata, 8'h44);
      addr_swap = 1'b0; host_addr = 2'b00; host_wdata = 8'h01;
      host_wr = 1'b1; host_rd = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
      check("R12 rdata held", host_rdata, 8'h44);
      acc(OP_CR, 1'b0, 2'b00, 8'h00);
      check("R12 write took effect", host_rdata, 8'h07);

      // R11 back-to-back chain
      acc(OP_CW, 1'b0, 2'b10, 8'h0C);
      acc(OP_CW, 1'b0, 2'b10, 8'h42);
      acc(OP_CW, 1'b0, 2'b10, 8'h0C);
      acc(OP_CR, 1'b0, 2'b10, 8'h00);
      check("R11 consecutive accesses", host_rdata, 8'h42);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule